// File: doc/BRIEF.md
# Vertical-Crosswise Hierarchical Multiplier

This block multiplies two unsigned operands and returns the double-width product from a single output register. The product is formed without a conventional partial-product array. The operands are split into a low half and a high half. Each of the four half-width products is built column by column: a column collects every bit product whose bit indices add up to the column index, adds the carry left over from the column below, keeps the least significant bit as a result bit, and passes the rest upward as carry. The four half-products are then aligned by their weights and summed by ripple adders. Every cell of those adders is a full adder made from two 4:1 multiplexers.

The block has a valid/ready stream on each side. An operand pair is accepted on a rising edge where `in_valid` and `in_ready` are both high. The product appears one edge later with `out_valid` set. While `out_valid` is high and `out_ready` is low, the output beat is held unchanged and `in_ready` is low. This back-pressure passes straight through to the producer, because there is only one output slot. When the consumer takes the beat in the same cycle, a new pair can be accepted, so an always-ready consumer gets one product per cycle.

Top module: `vcm_mult`

## Requirements
- R1: For every pair of OPW-bit unsigned operands, the product delivered for an accepted pair equals in_a*in_b as an unsigned 2*OPW-bit number.
- R2: After an edge that accepts a pair (in_valid and in_ready high), out_valid is high and out_prod holds that pair's product.
- R3: While out_valid is high and out_ready is low, in_ready is low, and on the next edge out_prod and out_valid keep their values whatever in_valid, in_a and in_b do.
- R4: in_ready is high whenever out_valid is low or out_ready is high.
- R5: After an edge where the output beat is taken (out_valid and out_ready high) and no pair is accepted, out_valid is low.
- R6: A synchronous active-high reset clears out_valid to 0 and out_prod to 0 on the next rising edge.
- R7: If either operand of an accepted pair is zero, the delivered product is zero.
- R8: The delivered product never exceeds (2^OPW-1)^2; for OPW=8 the pair 255,255 yields 65025 (0xFE01).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operand pair present |
| in_ready | output | 1 | Block can take an operand pair this cycle |
| in_a | input | OPW | Multiplicand, unsigned |
| in_b | input | OPW | Multiplier, unsigned |
| out_valid | output | 1 | Product beat present |
| out_ready | input | 1 | Consumer takes the product beat this cycle |
| out_prod | output | 2*OPW | Unsigned product |

## Verification
A fault in the column carry logic, in a multiplexer data input, or in the alignment of a half-product corrupts out_prod only for certain operand bit patterns. The product register then shows the wrong value one edge after that pair is accepted. The full sweep over every operand pair therefore exposes a fault on the first pair whose bits reach it. Faults in the output register's control show within one or two cycles of the back-pressure, drain and reset sequences, as a beat that changes, is duplicated or is lost.

// File: rtl/vcm_pkg.sv
package vcm_pkg;
  // Default operand width; the block splits operands into two equal halves.
  localparam int unsigned VCM_OPW = 8;

  // Index of each half-width sub-product; the value also encodes which halves feed it.
  // Bit 0 selects the high half of A, bit 1 selects the high half of B.
  typedef enum logic [1:0] {
    Q_LL = 2'd0,
    Q_HL = 2'd1,
    Q_LH = 2'd2,
    Q_HH = 2'd3
  } vcm_quad_e;

  // Weight, in half-widths, at which a sub-product lands in the full product.
  function automatic int unsigned quad_weight(input int unsigned q);
    return (q & 1) + ((q >> 1) & 1);
  endfunction
endpackage

// File: rtl/vcm_mux_fa.sv
// Full adder built from two 4:1 multiplexers selected by {x,y}.
module vcm_mux_fa (
  input  logic x,
  input  logic y,
  input  logic ci,
  output logic s,
  output logic co
);
  logic [3:0] sum_data;
  logic [3:0] carry_data;

  // Sum mux: only the carry input and its complement are data.
  assign sum_data   = {ci, ~ci, ~ci, ci};
  // Carry mux: constant 0, carry, carry, constant 1.
  assign carry_data = {1'b1, ci, ci, 1'b0};

  always_comb begin
    case ({x, y})
      2'b00:   begin s = sum_data[0]; co = carry_data[0]; end
      2'b01:   begin s = sum_data[1]; co = carry_data[1]; end
      2'b10:   begin s = sum_data[2]; co = carry_data[2]; end
      default: begin s = sum_data[3]; co = carry_data[3]; end
    endcase
  end
endmodule

// File: rtl/vcm_ripple_add.sv
// W-bit ripple adder whose every cell is a multiplexer full adder.
module vcm_ripple_add #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] op_x,
  input  logic [W-1:0] op_y,
  output logic [W-1:0] sum,
  output logic         cout
);
  logic [W:0] chain;

  assign chain[0] = 1'b0;

  for (genvar g = 0; g < W; g++) begin : g_cell
    vcm_mux_fa u_fa (
      .x  (op_x[g]),
      .y  (op_y[g]),
      .ci (chain[g]),
      .s  (sum[g]),
      .co (chain[g+1])
    );
  end

  assign cout = chain[W];
endmodule

// File: rtl/vcm_col_mult.sv
// N x N unsigned multiplier formed column by column (vertical and crosswise).
module vcm_col_mult #(
  parameter int unsigned N = 4
) (
  input  logic [N-1:0]   mul_x,
  input  logic [N-1:0]   mul_y,
  output logic [2*N-1:0] prod
);
  // A column holds at most N bit products plus a carry of at most N.
  localparam int unsigned CW   = $clog2(2 * N + 1) + 1;
  localparam int unsigned NCOL = 2 * N - 1;

  logic [CW-1:0] col_sum;
  logic [CW-1:0] carry;

  always_comb begin
    carry = '0;
    prod  = '0;
    for (int k = 0; k < NCOL; k++) begin
      col_sum = carry;
      for (int i = 0; i < N; i++) begin
        if ((k - i) >= 0 && (k - i) < N) begin
          col_sum = col_sum + CW'(mul_x[i] & mul_y[k-i]);
        end
      end
      prod[k] = col_sum[0];
      carry   = col_sum >> 1;
    end
    // What is left after the last column is the top product bit.
    prod[2*N-1] = carry[0];
  end
endmodule

// File: rtl/vcm_mult.sv
module vcm_mult
  import vcm_pkg::*;
#(
  parameter int unsigned OPW = VCM_OPW
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [OPW-1:0]   in_a,
  input  logic [OPW-1:0]   in_b,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [2*OPW-1:0] out_prod
);
  localparam int unsigned H  = OPW / 2;
  localparam int unsigned PW = 2 * H;   // width of a half-product
  localparam int unsigned FW = 3 * H;   // width of the upper combining adder

  logic [PW-1:0]    part [4];
  logic [PW-1:0]    mid_sum;
  logic             mid_cout;
  logic [FW-1:0]    fin_x;
  logic [FW-1:0]    fin_y;
  logic [FW-1:0]    fin_sum;
  logic             fin_cout;
  logic [2*OPW-1:0] full_prod;
  logic             accept;

  // Four half-width column multipliers.
  for (genvar q = 0; q < 4; q++) begin : g_quad
    logic [H-1:0] qa;
    logic [H-1:0] qb;
    assign qa = q[0] ? in_a[OPW-1:H] : in_a[H-1:0];
    assign qb = q[1] ? in_b[OPW-1:H] : in_b[H-1:0];
    vcm_col_mult #(.N(H)) u_col (
      .mul_x (qa),
      .mul_y (qb),
      .prod  (part[q])
    );
  end

  // The two cross terms share weight H.
  vcm_ripple_add #(.W(PW)) u_mid_add (
    .op_x (part[Q_HL]),
    .op_y (part[Q_LH]),
    .sum  (mid_sum),
    .cout (mid_cout)
  );

  // Low and high terms do not overlap; the cross sum lands above the lowest H bits.
  assign fin_x = {part[Q_HH], part[Q_LL][PW-1:H]};
  assign fin_y = {{(FW-PW-1){1'b0}}, mid_cout, mid_sum};

  vcm_ripple_add #(.W(FW)) u_fin_add (
    .op_x (fin_x),
    .op_y (fin_y),
    .sum  (fin_sum),
    .cout (fin_cout)
  );

  assign full_prod = {fin_sum, part[Q_LL][H-1:0]};

  // One-slot output stage with valid/ready.
  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_prod  <= '0;
    end else if (accept) begin
      out_valid <= 1'b1;
      out_prod  <= full_prod;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/vcm_mult_chk.sv
module vcm_mult_chk #(
  parameter int unsigned OPW = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic             in_ready,
  input logic [OPW-1:0]   in_a,
  input logic [OPW-1:0]   in_b,
  input logic             out_valid,
  input logic             out_ready,
  input logic [2*OPW-1:0] out_prod,
  input logic             fin_cout
);
  localparam logic [2*OPW-1:0] MAXP = {OPW{1'b1}} * {OPW{1'b1}};

  AST_NO_FINAL_CARRY: assert property (@(posedge clk) disable iff (rst)
    in_valid |-> !fin_cout); // R1

  AST_ACCEPT_GIVES_VALID: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> out_valid); // R2

  AST_STALL_HOLDS_BEAT: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_prod))); // R3

  AST_STALL_BLOCKS_INPUT: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |-> !in_ready); // R3

  AST_READY_WHEN_FREE: assert property (@(posedge clk) disable iff (rst)
    (!out_valid || out_ready) |-> in_ready); // R4

  AST_DRAIN_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_ready && !in_valid) |=> !out_valid); // R5

  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> (!out_valid && out_prod == '0)); // R6

  AST_ZERO_OPERAND: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && (in_a == '0 || in_b == '0)) |=> (out_prod == '0)); // R7

  AST_PRODUCT_BOUND: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_prod <= MAXP)); // R8
endmodule

bind vcm_mult vcm_mult_chk #(.OPW(OPW)) u_vcm_mult_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .in_a      (in_a),
  .in_b      (in_b),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_prod  (out_prod),
  .fin_cout  (fin_cout)
);

// File: tb/test_vcm_mult.sv
`timescale 1ns/100ps
module test_vcm_mult;
  localparam int unsigned OPW = 8;
  localparam int unsigned NPAIR = 1 << (2 * OPW);

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             in_valid = 1'b0;
  logic             in_ready;
  logic [OPW-1:0]   in_a = '0;
  logic [OPW-1:0]   in_b = '0;
  logic             out_valid;
  logic             out_ready = 1'b1;
  logic [2*OPW-1:0] out_prod;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  vcm_mult #(.OPW(OPW)) i_vcm_mult (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_a      (in_a),
    .in_b      (in_b),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_prod  (out_prod)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #(5.0 * 190000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual 1 expected 0");
      summary();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R6: reset state
    chk(out_valid == 1'b0, "R6 reset valid", out_valid, 0);
    chk(out_prod == '0, "R6 reset product", out_prod, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(in_ready == 1'b1, "R4 idle ready", in_ready, 1);

    // R1: streaming sweep of every operand pair, consumer always ready
    for (int idx = 0; idx <= int'(NPAIR); idx++) begin
      @(negedge clk);
      if (idx > 0) begin
        automatic int pa = (idx - 1) >> OPW;
        automatic int pb = (idx - 1) & ((1 << OPW) - 1);
        automatic int ex = pa * pb;
        if (pa == 0 || pb == 0)
          chk(out_valid && out_prod == '0, "R7 zero operand", out_prod, 0);
        else if (pa == 255 && pb == 255)
          chk(out_valid && out_prod == 16'hFE01, "R8 max operands", out_prod, ex);
        else
          chk(out_valid && int'(out_prod) == ex, "R1 product", out_prod, ex);
      end
      if (idx < int'(NPAIR)) begin
        in_valid = 1'b1;
        in_a = OPW'(idx >> OPW);
        in_b = OPW'(idx);
      end else begin
        in_valid = 1'b0;
      end
    end
    @(negedge clk);
    chk(out_valid == 1'b0, "R5 drain after sweep", out_valid, 0);

    // R2/R3/R4: back-pressure
    in_valid = 1'b1; in_a = 8'd13; in_b = 8'd11; out_ready = 1'b0;
    @(negedge clk);
    chk(out_valid == 1'b1, "R2 valid after accept", out_valid, 1);
    chk(out_prod == 16'd143, "R2 product after accept", out_prod, 143);
    in_a = 8'd7; in_b = 8'd9;
    #0.5;
    chk(in_ready == 1'b0, "R3 ready low under stall", in_ready, 0);
    @(negedge clk);
    chk(out_valid == 1'b1, "R3 valid held", out_valid, 1);
    chk(out_prod == 16'd143, "R3 product held", out_prod, 143);
    out_ready = 1'b1;
    #0.5;
    chk(in_ready == 1'b1, "R4 ready when consumed", in_ready, 1);
    @(negedge clk);
    chk(out_prod == 16'd63, "R1 product after stall", out_prod, 63);
    in_valid = 1'b0;
    @(negedge clk);
    chk(out_valid == 1'b0, "R5 valid drops", out_valid, 0);

    // R6: reset while a beat is present
    in_valid = 1'b1; in_a = 8'd200; in_b = 8'd3;
    @(negedge clk);
    chk(out_prod == 16'd600, "R1 product before reset", out_prod, 600);
    in_valid = 1'b0; rst = 1'b1;
    @(negedge clk);
    chk(out_valid == 1'b0, "R6 reset clears valid", out_valid, 0);
    chk(out_prod == '0, "R6 reset clears product", out_prod, 0);
    rst = 1'b0;
    @(negedge clk);
    done = 1'b1;
    summary();
  end
endmodule